// File: doc/BRIEF.md
# Segment Translation Buffer

This block holds a small, fully associative set of segment entries that turn the upper bits of a 64-bit effective address into a segment descriptor word. Each entry is two 64-bit words: a tag word holding the segment number and a valid flag, and a descriptor word whose top two bits select the segment granularity, 256 MB or 1 TB. A translation front end presents an address on the lookup port and receives, in the same cycle, a hit flag, the index of the matching slot and that slot's descriptor word.

Software-visible maintenance happens through a store port, which writes the tag and descriptor words into a slot named by the low 12 bits of the tag operand, and through two read ports that return the tag word or the descriptor word of a slot one cycle later. Two invalidate commands exist: one clears the entry that an address hits, the other clears every slot except slot 0. Malformed stores and out-of-range reads produce a one-cycle error pulse. When an invalidate clears an entry that was valid, a one-cycle flush pulse tells downstream translation caches to discard their contents.

Top module: `seg_lookaside`

## Requirements
- R1: A slot hits a 256 MB lookup when its tag word bit 27 (valid) is 1, its descriptor bits 63:62 are 00, and its tag word equals address bits 63:28 with bit 27 set and bits 26:0 zero.
- R2: A slot hits a 1 TB lookup when its tag word bit 27 is 1, its descriptor bits 63:62 are 01, and its tag word equals address bits 63:40 followed by twelve zero bits, bit 27 set and bits 26:0 zero.
- R3: The lookup is combinational; with several hits the lowest slot index is reported together with its descriptor word; on a miss the hit flag, slot index and descriptor outputs are all zero.
- R4: A store writes slot number tag-operand bits 11:0; the stored tag word keeps operand bits 63:27 and zeroes bits 26:0; the descriptor word is stored whole; the entry is visible from the next cycle.
- R5: A store whose tag-operand bits 11:0 are at or above the slot count is rejected: no slot changes and the error output is high for the one following cycle.
- R6: A store is rejected the same way when descriptor bits 63:62 are 10 or 11, or are 01 while the 1 TB enable input is low.
- R7: Invalidate-all clears bit 27 of every slot except slot 0; the flush output pulses in the following cycle only if some slot other than slot 0 was valid.
- R8: Invalidate-by-address clears bit 27 of the lowest slot that the given address hits and pulses flush in the following cycle; on a miss nothing changes and flush stays low.
- R9: Each read port returns the selected slot's word in the cycle after its enable; a slot number at or above the slot count returns zero and pulses the error output.
- R10: When a store and an invalidate fall in the same cycle, the invalidate acts on the previous contents and the store is applied last, so the stored entry ends up exactly as written; flush depends only on the invalidate.
- R11: After reset every word of every slot is zero, and the error, flush and read-data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| big_seg_en_i | input | 1 | Permits stores of 1 TB entries |
| lk_addr_i | input | 64 | Lookup effective address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_slot_o | output | log2(NENT) | Index of the winning slot |
| lk_desc_o | output | 64 | Descriptor word of the winning slot |
| st_en_i | input | 1 | Store request |
| st_tag_i | input | 64 | Tag operand: segment number, valid bit 27, slot in bits 11:0 |
| st_desc_i | input | 64 | Descriptor word to store |
| rdt_en_i | input | 1 | Tag-word read request |
| rdt_slot_i | input | 12 | Slot for tag read |
| rdt_data_o | output | 64 | Tag word read result |
| rdd_en_i | input | 1 | Descriptor-word read request |
| rdd_slot_i | input | 12 | Slot for descriptor read |
| rdd_data_o | output | 64 | Descriptor word read result |
| inv_addr_en_i | input | 1 | Invalidate-by-address request |
| inv_addr_i | input | 64 | Address for invalidate-by-address |
| inv_all_en_i | input | 1 | Invalidate-all request |
| err_o | output | 1 | Illegal request pulse |
| flush_o | output | 1 | Translation flush pulse |

## Verification
A store and an invalidate can land in the same cycle, and the interesting case is when both aim at one slot. The bench drives the store enable together with invalidate-all, and separately together with an invalidate-by-address that hits the slot being rewritten. It judges the outcome at the ports: the next-cycle lookup and readback must show the freshly stored entry valid, while the flush pulse must match what the invalidate alone would have cleared from the earlier contents.

// File: rtl/seg_lookaside_pkg.sv
package seg_lookaside_pkg;
  localparam int WORD_W   = 64;
  localparam int VLD_BIT  = 27;
  localparam int SMALL_LO = 28;
  localparam int LARGE_LO = 40;
  localparam int SLOTF_W  = 12;

  typedef enum logic [1:0] {
    SZ_256M = 2'b00,
    SZ_1T   = 2'b01
  } seg_size_e;

  localparam logic [WORD_W-1:0] TAG_KEEP = {{(WORD_W-VLD_BIT){1'b1}}, {VLD_BIT{1'b0}}};
endpackage

// File: rtl/seg_match_array.sv
module seg_match_array
  import seg_lookaside_pkg::*;
#(
  parameter int NENT = 64
) (
  input  logic [NENT-1:0][WORD_W-1:0] tag_i,
  input  logic [NENT-1:0][WORD_W-1:0] desc_i,
  input  logic [WORD_W-1:0]           addr_i,
  output logic [NENT-1:0]             hit_o
);
  logic [WORD_W-1:0] key_small;
  logic [WORD_W-1:0] key_large;

  assign key_small = {addr_i[WORD_W-1:SMALL_LO], 1'b1, {VLD_BIT{1'b0}}};
  assign key_large = {addr_i[WORD_W-1:LARGE_LO], {(LARGE_LO-SMALL_LO){1'b0}},
                      1'b1, {VLD_BIT{1'b0}}};

  for (genvar g = 0; g < NENT; g++) begin : g_cmp
    logic [1:0] sz;
    logic       vld;
    assign sz  = desc_i[g][WORD_W-1:WORD_W-2];
    assign vld = tag_i[g][VLD_BIT];
    assign hit_o[g] = vld &&
                      (((sz == SZ_256M) && (tag_i[g] == key_small)) ||
                       ((sz == SZ_1T)   && (tag_i[g] == key_large)));
  end
endmodule

// File: rtl/seg_prio_enc.sv
module seg_prio_enc #(
  parameter int N = 64,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [N-1:0] req_i,
  output logic         found_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    found_o = |req_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end

  logic [N-1:0] below_mask;
  always_comb begin
    below_mask = '0;
    for (int i = 0; i < N; i++) below_mask[i] = (W'(i) < idx_o);
  end

  AST_PRIO_LOWEST: assert property (@(posedge clk_i) disable iff (rst_i)
    found_o |-> (req_i[idx_o] && ((req_i & below_mask) == '0)));  // R3
  AST_PRIO_MISS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    !found_o |-> (idx_o == '0));  // R3
endmodule

// File: rtl/seg_req_check.sv
module seg_req_check
  import seg_lookaside_pkg::*;
#(
  parameter int NENT = 64
) (
  input  logic              big_seg_en_i,
  input  logic [WORD_W-1:0] st_tag_i,
  input  logic [WORD_W-1:0] st_desc_i,
  input  logic [11:0]       rdt_slot_i,
  input  logic [11:0]       rdd_slot_i,
  output logic              st_bad_o,
  output logic              rdt_bad_o,
  output logic              rdd_bad_o
);
  localparam logic [SLOTF_W:0] LIMIT = (SLOTF_W+1)'(NENT);

  logic [1:0] sz;
  logic       slot_bad;
  logic       size_bad;

  assign sz       = st_desc_i[WORD_W-1:WORD_W-2];
  assign slot_bad = {1'b0, st_tag_i[SLOTF_W-1:0]} >= LIMIT;
  assign size_bad = sz[1] || ((sz == SZ_1T) && !big_seg_en_i);
  assign st_bad_o = slot_bad || size_bad;

  assign rdt_bad_o = {1'b0, rdt_slot_i} >= LIMIT;
  assign rdd_bad_o = {1'b0, rdd_slot_i} >= LIMIT;
endmodule

// File: rtl/seg_lookaside.sv
module seg_lookaside
  import seg_lookaside_pkg::*;
#(
  parameter int NENT = 64,
  localparam int SW = $clog2(NENT)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              big_seg_en_i,
  input  logic [63:0]       lk_addr_i,
  output logic              lk_hit_o,
  output logic [SW-1:0]     lk_slot_o,
  output logic [63:0]       lk_desc_o,
  input  logic              st_en_i,
  input  logic [63:0]       st_tag_i,
  input  logic [63:0]       st_desc_i,
  input  logic              rdt_en_i,
  input  logic [11:0]       rdt_slot_i,
  output logic [63:0]       rdt_data_o,
  input  logic              rdd_en_i,
  input  logic [11:0]       rdd_slot_i,
  output logic [63:0]       rdd_data_o,
  input  logic              inv_addr_en_i,
  input  logic [63:0]       inv_addr_i,
  input  logic              inv_all_en_i,
  output logic              err_o,
  output logic              flush_o
);
  logic [NENT-1:0][WORD_W-1:0] tag_q;
  logic [NENT-1:0][WORD_W-1:0] desc_q;
  logic [NENT-1:0]             valid_vec;

  for (genvar g = 0; g < NENT; g++) begin : g_vld
    assign valid_vec[g] = tag_q[g][VLD_BIT];
  end

  // Lookup path
  logic [NENT-1:0] lk_hits;
  logic            lk_found;
  logic [SW-1:0]   lk_idx;

  seg_match_array #(.NENT(NENT)) u_lk_match (
    .tag_i (tag_q),
    .desc_i(desc_q),
    .addr_i(lk_addr_i),
    .hit_o (lk_hits)
  );

  seg_prio_enc #(.N(NENT)) u_lk_prio (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .req_i  (lk_hits),
    .found_o(lk_found),
    .idx_o  (lk_idx)
  );

  assign lk_hit_o  = lk_found;
  assign lk_slot_o = lk_idx;
  assign lk_desc_o = lk_found ? desc_q[lk_idx] : '0;

  // Invalidate-by-address path
  logic [NENT-1:0] inv_hits;
  logic            inv_found;
  logic [SW-1:0]   inv_idx;

  seg_match_array #(.NENT(NENT)) u_inv_match (
    .tag_i (tag_q),
    .desc_i(desc_q),
    .addr_i(inv_addr_i),
    .hit_o (inv_hits)
  );

  seg_prio_enc #(.N(NENT)) u_inv_prio (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .req_i  (inv_hits),
    .found_o(inv_found),
    .idx_o  (inv_idx)
  );

  // Request legality
  logic st_bad, rdt_bad, rdd_bad;

  seg_req_check #(.NENT(NENT)) u_check (
    .big_seg_en_i(big_seg_en_i),
    .st_tag_i    (st_tag_i),
    .st_desc_i   (st_desc_i),
    .rdt_slot_i  (rdt_slot_i),
    .rdd_slot_i  (rdd_slot_i),
    .st_bad_o    (st_bad),
    .rdt_bad_o   (rdt_bad),
    .rdd_bad_o   (rdd_bad)
  );

  logic [SW-1:0] st_slot;
  logic          st_ok;
  logic          others_valid;

  assign st_slot      = st_tag_i[SW-1:0];
  assign st_ok        = st_en_i && !st_bad;
  assign others_valid = |valid_vec[NENT-1:1];

  // State update: invalidates first, store last
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tag_q      <= '0;
      desc_q     <= '0;
      err_o      <= 1'b0;
      flush_o    <= 1'b0;
      rdt_data_o <= '0;
      rdd_data_o <= '0;
    end else begin
      if (inv_all_en_i) begin
        for (int i = 1; i < NENT; i++) tag_q[i][VLD_BIT] <= 1'b0;
      end
      if (inv_addr_en_i && inv_found) begin
        tag_q[inv_idx][VLD_BIT] <= 1'b0;
      end
      if (st_ok) begin
        tag_q[st_slot]  <= st_tag_i & TAG_KEEP;
        desc_q[st_slot] <= st_desc_i;
      end

      if (rdt_en_i) rdt_data_o <= rdt_bad ? '0 : tag_q[rdt_slot_i[SW-1:0]];
      if (rdd_en_i) rdd_data_o <= rdd_bad ? '0 : desc_q[rdd_slot_i[SW-1:0]];

      err_o   <= (st_en_i && st_bad) || (rdt_en_i && rdt_bad) || (rdd_en_i && rdd_bad);
      flush_o <= (inv_all_en_i && others_valid) || (inv_addr_en_i && inv_found);
    end
  end

  AST_HIT_IS_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
    lk_hit_o |-> valid_vec[lk_slot_o]);  // R1
  AST_BAD_STORE_ERR: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_en_i && st_bad) |=> err_o);  // R5
  AST_SLOT0_KEPT: assert property (@(posedge clk_i) disable iff (rst_i)
    (inv_all_en_i && !inv_addr_en_i && !st_en_i) |=> $stable(tag_q[0]));  // R7
  AST_FLUSH_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
    flush_o |-> $past(inv_all_en_i || inv_addr_en_i));  // R8
  AST_BAD_READ_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (rdt_en_i && rdt_bad) |=> (rdt_data_o == '0));  // R9
  AST_STORE_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
    st_ok |=> (valid_vec[$past(st_slot)] == $past(st_tag_i[VLD_BIT])));  // R10
endmodule

// File: tb/seg_lookaside_bench.sv
module seg_lookaside_bench;
  localparam int NE = 8;
  localparam int SWB = $clog2(NE);

  logic clk_i = 1'b0;
  logic rst_i = 1'b1;
  always #4 clk_i = ~clk_i;

  logic            big_seg_en_i = 1'b1;
  logic [63:0]     lk_addr_i = '0;
  logic            lk_hit_o;
  logic [SWB-1:0]  lk_slot_o;
  logic [63:0]     lk_desc_o;
  logic            st_en_i = 1'b0;
  logic [63:0]     st_tag_i = '0;
  logic [63:0]     st_desc_i = '0;
  logic            rdt_en_i = 1'b0;
  logic [11:0]     rdt_slot_i = '0;
  logic [63:0]     rdt_data_o;
  logic            rdd_en_i = 1'b0;
  logic [11:0]     rdd_slot_i = '0;
  logic [63:0]     rdd_data_o;
  logic            inv_addr_en_i = 1'b0;
  logic [63:0]     inv_addr_i = '0;
  logic            inv_all_en_i = 1'b0;
  logic            err_o;
  logic            flush_o;

  seg_lookaside #(.NENT(NE)) u_seg_lookaside (.*);

  int n_cmp = 0;
  int n_bad = 0;

  logic [63:0] m_tag  [NE];
  logic [63:0] m_desc [NE];

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] base_s(input int i);
    return 64'h4A00_0000_0000_0000 | (64'(i) << 29);
  endfunction
  function automatic logic [63:0] base_l(input int i);
    return 64'hC300_0000_0000_0000 | (64'(i) << 41);
  endfunction
  function automatic logic [63:0] mk_tag(input logic [63:0] seg, input int slot);
    return (seg & 64'hFFFF_FFFF_F000_0000) | 64'h0800_0000 | 64'(slot);
  endfunction
  function automatic logic [63:0] mk_desc(input logic [1:0] sz, input int tagv);
    return {sz, 30'h0, 32'hD0C0_0000 + 32'(tagv)};
  endfunction

  // Expected lookup result from R1, R2, R3
  task automatic ref_lk(input logic [63:0] a, output bit h, output int s);
    h = 0; s = 0;
    for (int j = NE - 1; j >= 0; j--) begin
      bit v, m;
      v = m_tag[j][27];
      m = 0;
      if (m_desc[j][63:62] == 2'b00 && m_tag[j] == {a[63:28], 1'b1, 27'b0}) m = 1;
      if (m_desc[j][63:62] == 2'b01 && m_tag[j] == {a[63:40], 12'b0, 1'b1, 27'b0}) m = 1;
      if (v && m) begin h = 1; s = j; end
    end
  endtask

  task automatic probe(input logic [63:0] a, input string req);
    bit h; int s;
    lk_addr_i = a;
    #1;
    ref_lk(a, h, s);
    chk(req, "hit", 64'(lk_hit_o), 64'(h));
    chk(req, "slot", 64'(lk_slot_o), h ? 64'(s) : 64'h0);
    chk(req, "desc", lk_desc_o, h ? m_desc[s] : 64'h0);
  endtask

  task automatic sweep(input string req);
    logic [63:0] os [3] = '{64'h0, 64'h0FFF_FFFF, 64'h0123_4567};
    logic [63:0] ol [3] = '{64'h0, 64'hFF_FFFF_FFFF, 64'h12_3456_789A};
    for (int i = 0; i < NE; i++) begin
      for (int k = 0; k < 3; k++) begin
        probe(base_s(i) | os[k], req);
        probe(base_l(i) | ol[k], req);
      end
      probe(base_s(i) | 64'h1000_0000, req);
      probe(base_l(i) ^ (64'h1 << 40), req);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    st_en_i = 0; rdt_en_i = 0; rdd_en_i = 0; inv_addr_en_i = 0; inv_all_en_i = 0;
  endtask

  function automatic bit store_bad(input logic [63:0] t, input logic [63:0] d);
    return (t[11:0] >= 12'(NE)) || d[63] || (d[63:62] == 2'b01 && !big_seg_en_i);
  endfunction

  task automatic do_store(input logic [63:0] t, input logic [63:0] d, input string req);
    bit bad;
    bad = store_bad(t, d);
    st_en_i = 1; st_tag_i = t; st_desc_i = d;
    step();
    chk(req, "store err", 64'(err_o), 64'(bad));
    chk(req, "store flush", 64'(flush_o), 64'h0);
    if (!bad) begin
      m_tag[t[SWB-1:0]]  = t & 64'hFFFF_FFFF_F800_0000;
      m_desc[t[SWB-1:0]] = d;
    end
  endtask

  task automatic do_read(input int slot, input string req);
    bit bad;
    bad = slot >= NE;
    rdt_en_i = 1; rdt_slot_i = 12'(slot);
    rdd_en_i = 1; rdd_slot_i = 12'(slot);
    step();
    chk(req, "tag read", rdt_data_o, bad ? 64'h0 : m_tag[slot]);
    chk(req, "desc read", rdd_data_o, bad ? 64'h0 : m_desc[slot]);
    chk(req, "read err", 64'(err_o), 64'(bad));
  endtask

  task automatic do_inv_all(input string req);
    bit fl;
    fl = 0;
    for (int j = 1; j < NE; j++) if (m_tag[j][27]) fl = 1;
    inv_all_en_i = 1;
    step();
    chk(req, "inv-all flush", 64'(flush_o), 64'(fl));
    for (int j = 1; j < NE; j++) m_tag[j][27] = 1'b0;
  endtask

  task automatic do_inv_addr(input logic [63:0] a, input string req);
    bit h; int s;
    ref_lk(a, h, s);
    inv_addr_en_i = 1; inv_addr_i = a;
    step();
    chk(req, "inv-addr flush", 64'(flush_o), 64'(h));
    chk(req, "inv-addr err", 64'(err_o), 64'h0);
    if (h) m_tag[s][27] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int j = 0; j < NE; j++) begin m_tag[j] = '0; m_desc[j] = '0; end
    repeat (3) @(negedge clk_i);
    rst_i = 0;
    @(negedge clk_i);

    // R11: reset state
    chk("R11", "err", 64'(err_o), 64'h0);
    chk("R11", "flush", 64'(flush_o), 64'h0);
    chk("R11", "tag data", rdt_data_o, 64'h0);
    chk("R11", "desc data", rdd_data_o, 64'h0);
    probe(64'h0, "R11");
    probe(64'h0800_0000, "R11");
    for (int i = 0; i < NE; i++) do_read(i, "R11");

    // R4: fill every slot, even slots small segments, odd slots large ones
    for (int i = 0; i < NE; i++) begin
      if (i % 2 == 0) do_store(mk_tag(base_s(i), i) | 64'h07FF_F000, mk_desc(2'b00, i), "R4");
      else            do_store(mk_tag(base_l(i), i), mk_desc(2'b01, i), "R4");
    end
    // R9: readback, including out-of-range slots
    for (int i = 0; i < NE; i++) do_read(i, "R9");
    do_read(NE, "R9");
    do_read(12'hFFF, "R9");
    // R1, R2: lookups over all segments
    sweep("R1");
    sweep("R2");

    // R3: overlapping entries, lowest slot wins
    do_store(mk_tag(base_s(2), 6), mk_desc(2'b00, 66), "R3");
    do_store(mk_tag(64'h4A00_0000_0000_0000, 7), mk_desc(2'b01, 77), "R3");
    probe(base_s(2) | 64'h55, "R3");
    probe(64'h4A00_0000_0000_0010, "R3");
    probe(64'h4A00_0000_2000_0000, "R3");
    sweep("R3");

    // R5: slot field out of range
    do_store(mk_tag(base_s(1), NE), mk_desc(2'b00, 5), "R5");
    do_store(mk_tag(base_s(1), 12'h800), mk_desc(2'b00, 5), "R5");
    do_store(mk_tag(base_s(1), 12'hFFF), mk_desc(2'b00, 5), "R5");
    probe(base_s(1), "R5");
    sweep("R5");

    // R6: bad size codes and large segments while disabled
    do_store(mk_tag(base_s(1), 1), mk_desc(2'b10, 9), "R6");
    do_store(mk_tag(base_s(1), 1), mk_desc(2'b11, 9), "R6");
    big_seg_en_i = 0;
    do_store(mk_tag(base_l(3), 1), mk_desc(2'b01, 9), "R6");
    probe(base_l(3), "R6");
    do_store(mk_tag(base_s(1), 1), mk_desc(2'b00, 11), "R6");
    big_seg_en_i = 1;
    for (int i = 0; i < NE; i++) do_read(i, "R6");
    sweep("R6");

    // R8: invalidate by address, hit then miss
    do_inv_addr(base_s(0) | 64'h77, "R8");
    probe(base_s(0), "R8");
    do_inv_addr(64'h1111_0000_0000_0000, "R8");
    do_inv_addr(base_l(5), "R8");
    sweep("R8");

    // R7: invalidate-all keeps slot 0
    do_store(mk_tag(base_s(0), 0), mk_desc(2'b00, 100), "R7");
    do_inv_all("R7");
    probe(base_s(0), "R7");
    sweep("R7");
    do_inv_all("R7");
    do_read(0, "R7");

    // R10: store and invalidate-all in the same cycle
    do_store(mk_tag(base_s(4), 4), mk_desc(2'b00, 44), "R10");
    st_en_i = 1; st_tag_i = mk_tag(base_l(3), 3); st_desc_i = mk_desc(2'b01, 33);
    inv_all_en_i = 1;
    step();
    chk("R10", "flush with store+inv-all", 64'(flush_o), 64'h1);
    chk("R10", "err with store+inv-all", 64'(err_o), 64'h0);
    m_tag[4][27] = 1'b0;
    m_tag[3] = mk_tag(base_l(3), 3) & 64'hFFFF_FFFF_F800_0000;
    m_desc[3] = mk_desc(2'b01, 33);
    probe(base_l(3), "R10");
    do_read(3, "R10");
    // R10: store rewrites the slot that invalidate-by-address hits
    st_en_i = 1; st_tag_i = mk_tag(base_s(6), 3); st_desc_i = mk_desc(2'b00, 36);
    inv_addr_en_i = 1; inv_addr_i = base_l(3) | 64'h42;
    step();
    chk("R10", "flush with store+inv-addr", 64'(flush_o), 64'h1);
    m_tag[3] = mk_tag(base_s(6), 3) & 64'hFFFF_FFFF_F800_0000;
    m_desc[3] = mk_desc(2'b00, 36);
    probe(base_s(6), "R10");
    probe(base_l(3), "R10");
    do_read(3, "R10");
    sweep("R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule